// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block is the hazard and forwarding control for a five-stage in-order integer pipeline with fetch, decode, execute, memory and writeback stages. It looks at the register fields, the instruction class and the write flags that sit in the decode, execute, memory and writeback pipeline registers. From these it decides where each operand should come from and whether the front of the pipeline must wait. The datapath, the register file storage and the caches belong to the surrounding core. This block drives only their select and hold controls.

Each cycle it produces four kinds of control. The execute-stage operand selects choose between the register file value, the memory-stage ALU result and the writeback result. A memory-stage store-data select takes a value that has just been loaded. The decode-stage branch compare selects take an ALU result that is sitting in the memory stage. A stall freezes the PC and the fetch/decode register, and a matching bubble clears the execute-stage controls so that a no-op moves forward. Branches compare their registers in the decode stage. The register file is written in the first half of a cycle and read in the second half, so a writer three instructions ahead never needs a bypass.

Top module: `hazard_bypass_ctrl`

## Requirements
- R1: Class codes are ALU 00, load 01, store 10 and branch 11. Operand select codes are 00 for the register file, 01 for the memory-stage ALU result and 10 for the writeback result. When an ALU instruction writes a register that the next instruction uses as an ALU operand, the consumer's select in execute is 01 and there is no stall.
- R2: When an ALU result is the base register (first source) of the next load or store, the base select in execute is 01 and there is no stall.
- R3: A load followed at once by a store whose data register (second source) is the loaded register causes no stall. While the load is in the memory stage, the store's execute data select is 00. When the store is in the memory stage and the load is in writeback, the store-data select `mem_sd_sel` is 1.
- R4: When a loaded register is an ALU operand or the load base of the next instruction, there is exactly one stall cycle. After it, the consumer's execute select is 10.
- R5: When a loaded register is the base of the immediately following store, there is exactly one stall cycle.
- R6: A writer three instructions ahead of its consumer causes no stall and leaves the consumer's selects at 00.
- R7: For a branch in decode, the following apply. A source written by an ALU instruction in execute costs one stall. A source written by a load in execute costs two stalls. A source written by a load in memory costs one stall. A source written by an ALU instruction in memory sets the branch select to 1 with no stall.
- R8: `stall` and `bubble` are always equal. During a stall, the decode instruction is held and a no-op enters execute.
- R9: Register 0 never causes a stall and never produces a non-zero select.
- R10: When the memory and writeback stages both write the operand's register, the execute select is 01 (the younger writer wins).
- R11: An operand that the execute-stage class does not read has select 00. Loads and branches do not read the second source, and branches in execute read neither source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Synchronous active-low reset for the checks |
| id_cls | input | 2 | Class of the instruction in decode |
| id_rs1 | input | RW | First source (base/operand) in decode |
| id_rs2 | input | RW | Second source (operand/store data) in decode |
| ex_cls | input | 2 | Class of the instruction in execute |
| ex_rd | input | RW | Destination in execute |
| ex_we | input | 1 | Register write flag in execute |
| ex_rs1 | input | RW | First source in execute |
| ex_rs2 | input | RW | Second source in execute |
| mem_cls | input | 2 | Class of the instruction in memory |
| mem_rd | input | RW | Destination in memory |
| mem_we | input | 1 | Register write flag in memory |
| mem_rs2 | input | RW | Store data register in memory |
| wb_rd | input | RW | Destination in writeback |
| wb_we | input | 1 | Register write flag in writeback |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Clear execute-stage controls |
| ex_sel_a | output | 2 | Execute first-operand select |
| ex_sel_b | output | 2 | Execute second-operand select |
| mem_sd_sel | output | 1 | Store data taken from the writeback result |
| id_br_sel_a | output | 1 | Branch first compare operand from the memory-stage ALU result |
| id_br_sel_b | output | 1 | Branch second compare operand from the memory-stage ALU result |

## Verification
The situations hardest to reach from the ports depend on what happened in earlier cycles. One is a load followed at once by a store of the loaded value: a store-data select appears two cycles later, after an execute select that must stay at 00. Another is a branch waiting two cycles behind a load while the stall holds the decode slot. A third is two back-to-back writers of one register racing a reader. The bench drives the stage registers from its own pipeline model, which advances on its own expected stall. It runs directed sequences for each of these shapes and counts stall and select cycles. It then runs random programs that draw every register from only four values, including register 0, so that such collisions happen constantly.

// File: rtl/hbc_pkg.sv
// Shared encodings for the hazard/bypass controller.
// Assumes a two-bit instruction class and a two-bit operand select.
package hbc_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'b00,
        CLS_LOAD   = 2'b01,
        CLS_STORE  = 2'b10,
        CLS_BRANCH = 2'b11
    } icls_e;

    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_MEM = 2'b01,
        FWD_WB  = 2'b10
    } fwd_e;

    // Second source needed at decode time: ALU operand or branch compare.
    function automatic logic needs_b_early(input logic [1:0] cls);
        return (cls == CLS_ALU) || (cls == CLS_BRANCH);
    endfunction

    // First source read in execute: ALU operand or address base.
    function automatic logic ex_reads_a(input logic [1:0] cls);
        return cls != CLS_BRANCH;
    endfunction

    // Second source read in execute: ALU operand or store data.
    function automatic logic ex_reads_b(input logic [1:0] cls);
        return (cls == CLS_ALU) || (cls == CLS_STORE);
    endfunction

endpackage

// File: rtl/hbc_ex_bypass.sv
// Execute-stage operand source select for one operand.
// Does: picks the youngest in-flight writer of the operand's register.
// Assumes: a load in memory never feeds an ALU operand (hazard unit stalls);
// when it feeds store data the memory-stage select repairs the value.
module hbc_ex_bypass
    import hbc_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          use_i,
    input  logic [RW-1:0] src_i,
    input  logic          mem_we_i,
    input  logic [RW-1:0] mem_rd_i,
    input  logic          mem_load_i,
    input  logic          wb_we_i,
    input  logic [RW-1:0] wb_rd_i,
    output logic [1:0]    sel_o
);

    logic mem_hit;
    logic wb_hit;

    // Match the operand against each older writer, register 0 excluded.
    always_comb begin
        mem_hit = use_i && (src_i != '0) && mem_we_i && (mem_rd_i == src_i);
        wb_hit  = use_i && (src_i != '0) && wb_we_i && (wb_rd_i == src_i);
    end

    // Youngest writer wins; a memory-stage load hides older writers.
    always_comb begin
        if (mem_hit) begin
            sel_o = mem_load_i ? FWD_RF : FWD_MEM;
        end else if (wb_hit) begin
            sel_o = FWD_WB;
        end else begin
            sel_o = FWD_RF;
        end
    end

    p_sel_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o != FWD_RF) |-> (src_i != '0));

    p_mem_not_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o == FWD_MEM) |-> !mem_load_i);

    p_unused_rf_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !use_i |-> (sel_o == FWD_RF));

endmodule

// File: rtl/hbc_id_bypass.sv
// Decode-stage branch compare operand select for one operand.
// Does: flags when a branch source can take the memory-stage ALU result.
// Assumes: a match in execute or on a memory-stage load stalls instead.
module hbc_id_bypass
    import hbc_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          is_branch_i,
    input  logic [RW-1:0] src_i,
    input  logic          ex_we_i,
    input  logic [RW-1:0] ex_rd_i,
    input  logic          mem_we_i,
    input  logic [RW-1:0] mem_rd_i,
    input  logic [1:0]    mem_cls_i,
    output logic          sel_o
);

    logic ex_hit;
    logic mem_alu_hit;

    // Youngest writer in execute blocks the bypass; only ALU results qualify.
    always_comb begin
        ex_hit      = (src_i != '0) && ex_we_i && (ex_rd_i == src_i);
        mem_alu_hit = (src_i != '0) && mem_we_i && (mem_rd_i == src_i)
                      && (mem_cls_i != CLS_LOAD);
        sel_o       = is_branch_i && mem_alu_hit && !ex_hit;
    end

    p_br_sel_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> is_branch_i);

    p_br_sel_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> (src_i != '0));

endmodule

// File: rtl/hbc_hazard.sv
// Decode-stage hazard detection.
// Does: raises a stall when decode needs a value not yet producible:
// a load result for an operand, address base or branch compare, or any
// execute-stage result (or memory-stage load) for a decode branch compare.
// Assumes: store data is exempt, since it is repaired at the memory stage.
module hbc_hazard
    import hbc_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    id_cls_i,
    input  logic [RW-1:0] id_rs1_i,
    input  logic [RW-1:0] id_rs2_i,
    input  logic [1:0]    ex_cls_i,
    input  logic [RW-1:0] ex_rd_i,
    input  logic          ex_we_i,
    input  logic [1:0]    mem_cls_i,
    input  logic [RW-1:0] mem_rd_i,
    input  logic          mem_we_i,
    output logic          stall_o
);

    logic ex_hit_a;
    logic ex_hit_b;
    logic mem_hit_a;
    logic mem_hit_b;
    logic load_use;
    logic branch_wait;
    logic id_branch;

    // Per-source matches against the execute and memory writers.
    always_comb begin
        ex_hit_a  = (id_rs1_i != '0) && ex_we_i && (ex_rd_i == id_rs1_i);
        ex_hit_b  = (id_rs2_i != '0) && ex_we_i && (ex_rd_i == id_rs2_i);
        mem_hit_a = (id_rs1_i != '0) && mem_we_i && (mem_rd_i == id_rs1_i);
        mem_hit_b = (id_rs2_i != '0) && mem_we_i && (mem_rd_i == id_rs2_i);
        id_branch = (id_cls_i == CLS_BRANCH);
    end

    // Load-use: first source always read early, second only if not store data.
    always_comb begin
        load_use = (ex_cls_i == CLS_LOAD)
                   && (ex_hit_a || (needs_b_early(id_cls_i) && ex_hit_b));
    end

    // Branch compare waits on any execute writer or a memory-stage load.
    always_comb begin
        branch_wait = id_branch
                      && ((ex_hit_a || ex_hit_b)
                          || ((mem_cls_i == CLS_LOAD) && (mem_hit_a || mem_hit_b)));
        stall_o     = load_use || branch_wait;
    end

    p_zero_no_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_rs1_i == '0) && (id_rs2_i == '0)) |-> !stall_o);

    p_store_data_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_cls_i == CLS_STORE) && (id_rs1_i != ex_rd_i)) |-> !stall_o);

    p_branch_after_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((id_cls_i == CLS_BRANCH) && ex_we_i && (ex_cls_i == CLS_ALU)
         && (ex_rd_i != '0) && (id_rs1_i == ex_rd_i)) |-> stall_o);

    p_load_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_cls_i == CLS_LOAD) && ex_we_i && (ex_rd_i != '0)
         && (id_rs1_i == ex_rd_i)) |-> stall_o);

endmodule

// File: rtl/hazard_bypass_ctrl.sv
// Top of the hazard and operand bypass controller.
// Does: combines decode hazard detection, execute operand selects, branch
// compare selects in decode and the memory-stage store-data select.
// Assumes: stage registers are held by the core; stall holds PC and the
// fetch/decode register, bubble clears the execute-stage controls.
module hazard_bypass_ctrl
    import hbc_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    id_cls,
    input  logic [RW-1:0] id_rs1,
    input  logic [RW-1:0] id_rs2,
    input  logic [1:0]    ex_cls,
    input  logic [RW-1:0] ex_rd,
    input  logic          ex_we,
    input  logic [RW-1:0] ex_rs1,
    input  logic [RW-1:0] ex_rs2,
    input  logic [1:0]    mem_cls,
    input  logic [RW-1:0] mem_rd,
    input  logic          mem_we,
    input  logic [RW-1:0] mem_rs2,
    input  logic [RW-1:0] wb_rd,
    input  logic          wb_we,
    output logic          stall,
    output logic          bubble,
    output logic [1:0]    ex_sel_a,
    output logic [1:0]    ex_sel_b,
    output logic          mem_sd_sel,
    output logic          id_br_sel_a,
    output logic          id_br_sel_b
);

    localparam int NOPND = 2;

    logic [RW-1:0] ex_src  [NOPND];
    logic          ex_use  [NOPND];
    logic [1:0]    ex_sel  [NOPND];
    logic [RW-1:0] id_src  [NOPND];
    logic          br_sel  [NOPND];
    logic          hz_stall;
    logic          mem_load;

    // Gather per-operand sources and execute usage flags.
    always_comb begin
        ex_src[0] = ex_rs1;
        ex_src[1] = ex_rs2;
        ex_use[0] = ex_reads_a(ex_cls);
        ex_use[1] = ex_reads_b(ex_cls);
        id_src[0] = id_rs1;
        id_src[1] = id_rs2;
        mem_load  = (mem_cls == CLS_LOAD);
    end

    hbc_hazard #(.RW(RW)) u_hazard (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_cls_i  (id_cls),
        .id_rs1_i  (id_rs1),
        .id_rs2_i  (id_rs2),
        .ex_cls_i  (ex_cls),
        .ex_rd_i   (ex_rd),
        .ex_we_i   (ex_we),
        .mem_cls_i (mem_cls),
        .mem_rd_i  (mem_rd),
        .mem_we_i  (mem_we),
        .stall_o   (hz_stall)
    );

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        hbc_ex_bypass #(.RW(RW)) u_ex_byp (
            .clk        (clk),
            .rst_n      (rst_n),
            .use_i      (ex_use[g]),
            .src_i      (ex_src[g]),
            .mem_we_i   (mem_we),
            .mem_rd_i   (mem_rd),
            .mem_load_i (mem_load),
            .wb_we_i    (wb_we),
            .wb_rd_i    (wb_rd),
            .sel_o      (ex_sel[g])
        );

        hbc_id_bypass #(.RW(RW)) u_id_byp (
            .clk         (clk),
            .rst_n       (rst_n),
            .is_branch_i (id_cls == CLS_BRANCH),
            .src_i       (id_src[g]),
            .ex_we_i     (ex_we),
            .ex_rd_i     (ex_rd),
            .mem_we_i    (mem_we),
            .mem_rd_i    (mem_rd),
            .mem_cls_i   (mem_cls),
            .sel_o       (br_sel[g])
        );
    end

    // Store in memory takes its data from whatever writeback now carries.
    always_comb begin
        mem_sd_sel = (mem_cls == CLS_STORE) && (mem_rs2 != '0)
                     && wb_we && (wb_rd == mem_rs2);
    end

    // Drive the outputs; the bubble follows the freeze one for one.
    always_comb begin
        stall       = hz_stall;
        bubble      = hz_stall;
        ex_sel_a    = ex_sel[0];
        ex_sel_b    = ex_sel[1];
        id_br_sel_a = br_sel[0];
        id_br_sel_b = br_sel[1];
    end

    p_sd_store_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sd_sel |-> ((mem_cls == CLS_STORE) && wb_we));

    p_sd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sd_sel |-> (wb_rd != '0));

endmodule

// File: tb/hazard_bypass_ctrl_tb.sv
module hazard_bypass_ctrl_tb;
    import hbc_pkg::*;

    typedef struct packed {
        logic [1:0] cls;
        logic       we;
        logic [4:0] rd;
        logic [4:0] rs1;
        logic [4:0] rs2;
    } ins_t;

    localparam ins_t NOP = '{cls: 2'b00, we: 1'b0, rd: 5'd0, rs1: 5'd0, rs2: 5'd0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    ins_t prog [0:255];
    int   prog_len;
    int   pc;
    ins_t id_q = NOP, ex_q = NOP, mem_q = NOP, wb_q = NOP;

    int tests = 0, fails = 0;
    int n_stall, n_bub, n_sd, n_br, n_a_mem, n_a_wb, n_b_mem, n_b_wb, n_hold;

    logic       stall, bubble, mem_sd_sel, id_br_sel_a, id_br_sel_b;
    logic [1:0] ex_sel_a, ex_sel_b;

    hazard_bypass_ctrl #(.RW(5)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_cls(id_q.cls), .id_rs1(id_q.rs1), .id_rs2(id_q.rs2),
        .ex_cls(ex_q.cls), .ex_rd(ex_q.rd), .ex_we(ex_q.we),
        .ex_rs1(ex_q.rs1), .ex_rs2(ex_q.rs2),
        .mem_cls(mem_q.cls), .mem_rd(mem_q.rd), .mem_we(mem_q.we), .mem_rs2(mem_q.rs2),
        .wb_rd(wb_q.rd), .wb_we(wb_q.we),
        .stall(stall), .bubble(bubble), .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b),
        .mem_sd_sel(mem_sd_sel), .id_br_sel_a(id_br_sel_a), .id_br_sel_b(id_br_sel_b)
    );

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic hit(input ins_t w, input logic [4:0] rs);
        return w.we && (w.rd != 5'd0) && (w.rd == rs);
    endfunction

    function automatic logic ref_stall(input ins_t i, input ins_t e, input ins_t m);
        logic s = 1'b0;
        if (e.cls == CLS_LOAD && hit(e, i.rs1)) s = 1'b1;
        if (e.cls == CLS_LOAD && (i.cls == CLS_ALU || i.cls == CLS_BRANCH) && hit(e, i.rs2)) s = 1'b1;
        if (i.cls == CLS_BRANCH && (hit(e, i.rs1) || hit(e, i.rs2))) s = 1'b1;
        if (i.cls == CLS_BRANCH && m.cls == CLS_LOAD && (hit(m, i.rs1) || hit(m, i.rs2))) s = 1'b1;
        return s;
    endfunction

    function automatic logic [1:0] ref_sel(input logic used, input logic [4:0] rs,
                                           input ins_t m, input ins_t w);
        if (!used) return 2'b00;
        if (hit(m, rs)) return (m.cls == CLS_LOAD) ? 2'b00 : 2'b01;
        if (hit(w, rs)) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic ref_br(input ins_t i, input ins_t e, input ins_t m,
                                    input logic [4:0] rs);
        return (i.cls == CLS_BRANCH) && !hit(e, rs) && (m.cls != CLS_LOAD) && hit(m, rs);
    endfunction

    // One pipeline cycle: compare every output with the model, then advance.
    task automatic cycle_step();
        logic e_st;
        ins_t id_before;
        @(posedge clk);
        #2;
        e_st = ref_stall(id_q, ex_q, mem_q);
        check("R4 stall", int'(stall), int'(e_st));
        check("R8 bubble", int'(bubble), int'(e_st));
        check("R1 ex_sel_a", int'(ex_sel_a),
              int'(ref_sel(ex_q.cls != CLS_BRANCH, ex_q.rs1, mem_q, wb_q)));
        check("R11 ex_sel_b", int'(ex_sel_b),
              int'(ref_sel(ex_q.cls == CLS_ALU || ex_q.cls == CLS_STORE, ex_q.rs2, mem_q, wb_q)));
        check("R3 mem_sd_sel", int'(mem_sd_sel),
              int'(mem_q.cls == CLS_STORE && hit(wb_q, mem_q.rs2)));
        check("R7 id_br_sel_a", int'(id_br_sel_a), int'(ref_br(id_q, ex_q, mem_q, id_q.rs1)));
        check("R7 id_br_sel_b", int'(id_br_sel_b), int'(ref_br(id_q, ex_q, mem_q, id_q.rs2)));
        n_stall += int'(stall);
        n_bub   += int'(bubble);
        n_sd    += int'(mem_sd_sel);
        n_br    += int'(id_br_sel_a) + int'(id_br_sel_b);
        n_a_mem += int'(ex_sel_a == 2'b01);
        n_a_wb  += int'(ex_sel_a == 2'b10);
        n_b_mem += int'(ex_sel_b == 2'b01);
        n_b_wb  += int'(ex_sel_b == 2'b10);
        id_before = id_q;
        wb_q  = mem_q;
        mem_q = ex_q;
        if (e_st) begin
            ex_q = NOP;
            if (id_q == id_before) n_hold++;
        end else begin
            ex_q = id_q;
            if (pc < prog_len) begin
                id_q = prog[pc];
                pc++;
            end else begin
                id_q = NOP;
            end
        end
    endtask

    task automatic run_prog();
        id_q = NOP; ex_q = NOP; mem_q = NOP; wb_q = NOP; pc = 0;
        n_stall = 0; n_bub = 0; n_sd = 0; n_br = 0; n_hold = 0;
        n_a_mem = 0; n_a_wb = 0; n_b_mem = 0; n_b_wb = 0;
        for (int c = 0; c < prog_len * 3 + 8; c++) cycle_step();
    endtask

    task automatic put(input int idx, input logic [1:0] c, input int rd,
                       input int rs1, input int rs2);
        prog[idx].cls = c;
        prog[idx].we  = (c == CLS_ALU) || (c == CLS_LOAD);
        prog[idx].rd  = 5'(rd);
        prog[idx].rs1 = 5'(rs1);
        prog[idx].rs2 = 5'(rs2);
    endtask

    initial begin
        #(8 * 150000);
        tests++;
        fails++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // Reset state with an empty pipeline.
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset stall", int'(stall), 0);
        check("R1 reset sel_a", int'(ex_sel_a), 0);
        check("R11 reset sel_b", int'(ex_sel_b), 0);
        check("R3 reset sd", int'(mem_sd_sel), 0);
        rst_n = 1'b1;

        // R4: load then ALU use -> one stall, then writeback select.
        prog_len = 2; put(0, CLS_LOAD, 1, 2, 0); put(1, CLS_ALU, 3, 1, 4);
        run_prog();
        check("R4 load-use stalls", n_stall, 1);
        check("R4 wb select", n_a_wb, 1);
        check("R8 held decode", n_hold, 1);
        check("R8 bubble count", n_bub, 1);

        // R4: load then load base -> one stall.
        prog_len = 2; put(0, CLS_LOAD, 1, 2, 0); put(1, CLS_LOAD, 5, 1, 0);
        run_prog();
        check("R4 load-base stalls", n_stall, 1);

        // R3: load then store of the loaded value.
        prog_len = 2; put(0, CLS_LOAD, 1, 2, 0); put(1, CLS_STORE, 0, 3, 1);
        run_prog();
        check("R3 no stall", n_stall, 0);
        check("R3 sd select", n_sd, 1);
        check("R3 ex data sel", n_b_mem + n_b_wb, 0);

        // R5: load then store using loaded register as base.
        prog_len = 2; put(0, CLS_LOAD, 1, 2, 0); put(1, CLS_STORE, 0, 1, 3);
        run_prog();
        check("R5 store base stalls", n_stall, 1);

        // R1: ALU to ALU on both operands.
        prog_len = 2; put(0, CLS_ALU, 1, 2, 3); put(1, CLS_ALU, 5, 1, 1);
        run_prog();
        check("R1 no stall", n_stall, 0);
        check("R1 sel_a mem", n_a_mem, 1);
        check("R1 sel_b mem", n_b_mem, 1);

        // R2: ALU result as load base.
        prog_len = 2; put(0, CLS_ALU, 1, 2, 3); put(1, CLS_LOAD, 4, 1, 0);
        run_prog();
        check("R2 no stall", n_stall, 0);
        check("R2 base sel", n_a_mem, 1);

        // R6: writer three ahead.
        prog_len = 4; put(0, CLS_ALU, 1, 2, 3); put(1, CLS_ALU, 6, 7, 8);
        put(2, CLS_ALU, 9, 10, 11); put(3, CLS_ALU, 12, 1, 1);
        run_prog();
        check("R6 no stall", n_stall, 0);
        check("R6 no bypass", n_a_mem + n_a_wb + n_b_mem + n_b_wb, 0);

        // R7: ALU then branch; load then branch; load, gap, branch; ALU, gap, branch.
        prog_len = 2; put(0, CLS_ALU, 1, 2, 3); put(1, CLS_BRANCH, 0, 1, 4);
        run_prog();
        check("R7 alu-branch stalls", n_stall, 1);
        check("R7 alu-branch br sel", n_br, 1);
        prog_len = 2; put(0, CLS_LOAD, 1, 2, 0); put(1, CLS_BRANCH, 0, 4, 1);
        run_prog();
        check("R7 load-branch stalls", n_stall, 2);
        prog_len = 3; put(0, CLS_LOAD, 1, 2, 0); put(1, CLS_ALU, 6, 7, 8);
        put(2, CLS_BRANCH, 0, 1, 4);
        run_prog();
        check("R7 load-gap-branch stalls", n_stall, 1);
        prog_len = 3; put(0, CLS_ALU, 1, 2, 3); put(1, CLS_ALU, 6, 7, 8);
        put(2, CLS_BRANCH, 0, 4, 1);
        run_prog();
        check("R7 alu-gap-branch stalls", n_stall, 0);
        check("R7 alu-gap-branch sel", n_br, 1);

        // R10: two writers of one register, youngest wins.
        prog_len = 3; put(0, CLS_ALU, 1, 2, 3); put(1, CLS_ALU, 1, 2, 3);
        put(2, CLS_ALU, 5, 1, 6);
        run_prog();
        check("R10 youngest mem", n_a_mem, 1);
        check("R10 no wb pick", n_a_wb, 0);

        // R9: register 0 as destination of a load.
        prog_len = 2; put(0, CLS_LOAD, 0, 2, 0); put(1, CLS_ALU, 3, 0, 0);
        run_prog();
        check("R9 zero no stall", n_stall, 0);
        check("R9 zero no sel", n_a_mem + n_a_wb + n_b_mem + n_b_wb, 0);

        // R11: load does not read its second source.
        prog_len = 2; put(0, CLS_ALU, 1, 2, 3); put(1, CLS_LOAD, 5, 2, 1);
        run_prog();
        check("R11 load rs2 unused", n_b_mem + n_b_wb, 0);

        // Random programs over four registers.
        for (int r = 0; r < 4; r++) begin
            prog_len = 200;
            for (int i = 0; i < 200; i++) begin
                if ($urandom_range(0, 7) == 0) begin
                    prog[i] = NOP;
                end else begin
                    put(i, 2'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                        int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
                end
            end
            run_prog();
            check("R8 random bubble count", n_bub, n_stall);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule